// File: doc/BRIEF.md
# Board Control Register and Interrupt Aggregator

This block sits on a simple single-cycle register bus and holds a small bank of 32-bit board-control registers: two LED data words, an LED control word, a switch word, three miscellaneous write words, a miscellaneous read word and two card-slot words. Each is plain storage that reads back what was last written. An access to any offset outside the map changes nothing and raises a one-cycle error flag.

The same block combines sixteen external level-sensitive interrupt inputs into one request line for the host. A raw level register samples every input each cycle. A mask-enable register chooses which inputs may interrupt. When an enabled input changes, the status register is overwritten with a one-hot word that names that input, and the request line takes that input's new level. When software writes the mask-enable register, the block recomputes a per-source output word: the raw level XOR the status register.

Top module: `board_irq_regs`

## Requirements
- R1: A synchronous active-high reset clears every register, the raw level register, the read data, the error flag, the request line and the per-source output word to zero.
- R2: The storage registers sit at offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4. Each keeps all 32 bits written to it and returns them on a read.
- R3: Read data is registered. It is valid on the cycle after a read strobe and otherwise holds its last value.
- R4: When input i differs from its sampled raw level and bit i of the mask-enable register (offset 0xC0) is set, the status register (offset 0xD0) becomes 1 shifted left by i. The request line takes the new level of input i on the same clock edge.
- R5: A change on an input whose mask bit is clear updates only the raw level. Status and the request line are left as they were.
- R6: When several enabled inputs change in the same cycle, the lowest-numbered one sets the status register and the request line.
- R7: Writes to mask-enable and status are ANDed with 0x000FEEFF. Bits 8 and 12, and every bit above 19, always read back as zero.
- R8: A write to mask-enable loads the per-source output word with the raw level XOR the low 16 bits of status, both taken from before that edge. The word changes at no other time except reset.
- R9: An access to an unmapped offset changes no state. A read of such an offset returns zero. The error flag is high for exactly the one cycle after the strobe.
- R10: If an enabled input change and a bus write to status happen on the same edge, the input change sets the status value.
- R11: An input change is tested against the mask value from before the edge, even when the mask is written on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 20 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bad_access | output | 1 | One-cycle flag for an unmapped access |
| irq_in | input | 16 | External interrupt levels |
| irq_parent | output | 1 | Request line to the host |
| src_out | output | 16 | Per-source word recomputed on a mask write |

## Verification
The assertions assume that inputs are sampled cleanly at the clock edge. They also assume that `irq_in` is held low while reset is active, so the raw level and the request line start from a known zero. The bench drives every input on the falling edge and keeps `irq_in` at zero until reset is released. Its bus strobes last exactly one cycle, which matches the assumption that each access is a single event.

// File: rtl/board_irq_regs.sv
module board_irq_regs #(
  parameter int NSRC = 16,
  parameter int AW = 20,
  parameter int DW = 32,
  parameter logic [DW-1:0] IRQ_WMASK = 32'h000FEEFF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bad_access,
  input  logic [NSRC-1:0] irq_in,
  output logic            irq_parent,
  output logic [NSRC-1:0] src_out
);
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [AW-1:0] A_LED1 = AW'('h10), A_LED2 = AW'('h14), A_LEDC = AW'('h40),
    A_SWCH = AW'('h60), A_MW1 = AW'('h80), A_MW2 = AW'('h84), A_MW3 = AW'('h88),
    A_MRD = AW'('h90), A_MASK = AW'('hC0), A_STAT = AW'('hD0),
    A_SLT0 = AW'('hE0), A_SLT1 = AW'('hE4);

  logic [DW-1:0] led1, led2, ledc, swch, mw1, mw2, mw3, mrd, mask_r, stat_r, slt0, slt1;
  logic [NSRC-1:0] lvl;
  logic [DW-1:0] rd_mux;
  logic hit;
  logic [SW-1:0] win;

  wire wr = bus_valid & bus_write;
  wire rd = bus_valid & ~bus_write;
  wire [NSRC-1:0] ev = (irq_in ^ lvl) & mask_r[NSRC-1:0];

  always_comb begin
    hit = 1'b1;
    rd_mux = '0;
    case (bus_addr)
      A_LED1: rd_mux = led1;
      A_LED2: rd_mux = led2;
      A_LEDC: rd_mux = ledc;
      A_SWCH: rd_mux = swch;
      A_MW1:  rd_mux = mw1;
      A_MW2:  rd_mux = mw2;
      A_MW3:  rd_mux = mw3;
      A_MRD:  rd_mux = mrd;
      A_MASK: rd_mux = mask_r;
      A_STAT: rd_mux = stat_r;
      A_SLT0: rd_mux = slt0;
      A_SLT1: rd_mux = slt1;
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (ev[i]) win = SW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {led1, led2, ledc, swch, mw1, mw2, mw3, mrd} <= '0;
      {mask_r, stat_r, slt0, slt1} <= '0;
      lvl <= '0;
      bus_rdata <= '0;
      bad_access <= 1'b0;
      irq_parent <= 1'b0;
      src_out <= '0;
    end else begin
      lvl <= irq_in;
      bad_access <= bus_valid & ~hit;
      if (rd) bus_rdata <= rd_mux;
      if (wr) begin
        case (bus_addr)
          A_LED1: led1 <= bus_wdata;
          A_LED2: led2 <= bus_wdata;
          A_LEDC: ledc <= bus_wdata;
          A_SWCH: swch <= bus_wdata;
          A_MW1:  mw1  <= bus_wdata;
          A_MW2:  mw2  <= bus_wdata;
          A_MW3:  mw3  <= bus_wdata;
          A_MRD:  mrd  <= bus_wdata;
          A_MASK: begin
            mask_r  <= bus_wdata & IRQ_WMASK;
            src_out <= lvl ^ stat_r[NSRC-1:0];
          end
          A_STAT: stat_r <= bus_wdata & IRQ_WMASK;
          A_SLT0: slt0 <= bus_wdata;
          A_SLT1: slt1 <= bus_wdata;
          default: ;
        endcase
      end
      if (|ev) begin
        stat_r <= DW'(1) << win;
        irq_parent <= irq_in[win];
      end
    end
  end
endmodule

// File: rtl/board_irq_regs_chk.sv
module board_irq_regs_chk #(
  parameter int NSRC = 16,
  parameter int AW = 20,
  parameter int DW = 32,
  parameter logic [DW-1:0] IRQ_WMASK = 32'h000FEEFF
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_valid,
  input logic            bus_write,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_rdata,
  input logic            bad_access,
  input logic [NSRC-1:0] irq_in,
  input logic            irq_parent,
  input logic [NSRC-1:0] src_out,
  input logic [NSRC-1:0] lvl
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_parent == 1'b0 && bad_access == 1'b0 && src_out == '0 && bus_rdata == '0));

  a_r9_flag_after_strobe: assert property (@(posedge clk) disable iff (rst)
    bad_access |-> $past(bus_valid));

  a_r3_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_valid && !bus_write)) |-> $stable(bus_rdata));

  a_r4_parent_needs_change: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(irq_parent)) |-> $past(irq_in != lvl));

  a_r8_src_only_on_mask_write: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(src_out)) |-> $past(bus_valid && bus_write && bus_addr == AW'('hC0)));

  a_r7_mask_readback: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_valid && !bus_write && bus_addr == AW'('hC0))) |-> ((bus_rdata & ~IRQ_WMASK) == '0));
endmodule

bind board_irq_regs board_irq_regs_chk #(.NSRC(NSRC), .AW(AW), .DW(DW), .IRQ_WMASK(IRQ_WMASK)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .bad_access(bad_access), .irq_in(irq_in), .irq_parent(irq_parent),
  .src_out(src_out), .lvl(lvl)
);

// File: tb/board_irq_regs_bench.sv
module board_irq_regs_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [19:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bad_access, irq_parent;
  logic [15:0] irq_in = '0;
  logic [15:0] src_out;

  int n_chk = 0, n_fail = 0;
  bit live = 0;

  always #5 clk = ~clk;

  board_irq_regs u_board_irq_regs (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bad_access(bad_access),
    .irq_in(irq_in), .irq_parent(irq_parent), .src_out(src_out)
  );

  int offs[12] = '{'h10, 'h14, 'h40, 'h60, 'h80, 'h84, 'h88, 'h90, 'hC0, 'hD0, 'hE0, 'hE4};
  logic [31:0] m_reg [int];
  logic [31:0] m_rd;
  logic [15:0] m_lvl, m_src;
  logic m_par, m_bad;

  always @(posedge clk) begin
    logic [31:0] old_mask, old_stat, v;
    if (rst) begin
      foreach (offs[i]) m_reg[offs[i]] = 32'h0;
      m_lvl = '0; m_src = '0; m_par = 1'b0; m_bad = 1'b0; m_rd = '0;
    end else begin
      old_mask = m_reg['hC0];
      old_stat = m_reg['hD0];
      m_bad = 1'b0;
      if (bus_valid) begin
        if (m_reg.exists(int'(bus_addr))) begin
          if (bus_write) begin
            v = bus_wdata;
            if (bus_addr == 'hC0 || bus_addr == 'hD0) v = v & 32'h000FEEFF;
            if (bus_addr == 'hC0) m_src = m_lvl ^ old_stat[15:0];
            m_reg[int'(bus_addr)] = v;
          end else m_rd = m_reg[int'(bus_addr)];
        end else begin
          m_bad = 1'b1;
          if (!bus_write) m_rd = '0;
        end
      end
      for (int i = 0; i < 16; i++)
        if (irq_in[i] != m_lvl[i] && old_mask[i]) begin
          m_reg['hD0] = 32'd1 << i;
          m_par = irq_in[i];
          break;
        end
      m_lvl = irq_in;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (live) begin
    chk("R3 rdata vs model", bus_rdata, m_rd);
    chk("R9 bad_access vs model", {31'b0, bad_access}, {31'b0, m_bad});
    chk("R4 irq_parent vs model", {31'b0, irq_parent}, {31'b0, m_par});
    chk("R8 src_out vs model", {16'b0, src_out}, {16'b0, m_src});
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 20'(a); bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 20'(a);
    @(negedge clk);
    bus_valid = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic set_irq(logic [15:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset rdata", bus_rdata, 32'h0);
    chk("R1 reset parent", {31'b0, irq_parent}, 32'h0);
    chk("R1 reset src_out", {16'b0, src_out}, 32'h0);
    live = 1;
    foreach (offs[i]) rd(offs[i], 32'h0, "R1 register zero after reset");

    foreach (offs[i])
      if (offs[i] != 'hC0 && offs[i] != 'hD0) wr(offs[i], 32'hA5C3_0000 ^ (32'(offs[i]) * 32'h0101_0101));
    foreach (offs[i])
      if (offs[i] != 'hC0 && offs[i] != 'hD0) rd(offs[i], 32'hA5C3_0000 ^ (32'(offs[i]) * 32'h0101_0101), "R2 readback");

    wr('h44, 32'hFFFF_FFFF);
    chk("R9 flag after bad write", {31'b0, bad_access}, 32'h1);
    rd('h44, 32'h0, "R9 bad read returns zero");
    rd('h10, 32'hA5C3_0000 ^ 32'h1010_1010, "R9 bad write left state alone");

    wr('hC0, 32'hFFFF_FFFF);
    rd('hC0, 32'h000F_EEFF, "R7 mask pattern");
    wr('hD0, 32'hFFFF_FFFF);
    rd('hD0, 32'h000F_EEFF, "R7 status pattern");

    wr('hC0, 32'h0000_00F0);
    set_irq(16'h0004);
    rd('hD0, 32'h000F_EEFF, "R5 masked change leaves status");
    chk("R5 masked change leaves parent", {31'b0, irq_parent}, 32'h0);

    set_irq(16'h0024);
    rd('hD0, 32'h0000_0020, "R4 enabled change one-hot");
    chk("R4 parent follows new level", {31'b0, irq_parent}, 32'h1);

    set_irq(16'h00E4);
    rd('hD0, 32'h0000_0040, "R6 lowest source wins");
    chk("R6 parent from lowest", {31'b0, irq_parent}, 32'h1);
    set_irq(16'h00A4);
    rd('hD0, 32'h0000_0040, "R4 falling level");
    chk("R4 parent low after fall", {31'b0, irq_parent}, 32'h0);

    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 20'hD0; bus_wdata = 32'h0000_0800;
    irq_in = 16'h00B4;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    rd('hD0, 32'h0000_0010, "R10 input event beats status write");

    wr('hD0, 32'h0000_0003);
    wr('hC0, 32'h0000_00F0);
    chk("R8 src_out is level xor status", {16'b0, src_out}, {16'b0, 16'h00B4 ^ 16'h0003});

    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 20'hC0; bus_wdata = 32'h0000_0001;
    irq_in = 16'h00B5;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    rd('hD0, 32'h0000_0003, "R11 change tested against old mask");
    irq_in = 16'h00B4;
    @(negedge clk);
    rd('hD0, 32'h0000_0001, "R11 new mask now active");

    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) irq_in = irq_in ^ (16'd1 << $urandom_range(0, 15));
      bus_valid = ($urandom_range(0, 2) == 0);
      bus_write = $urandom_range(0, 1);
      case ($urandom_range(0, 5))
        0: bus_addr = 20'hC0;
        1: bus_addr = 20'hD0;
        2: bus_addr = 20'($urandom_range(0, 'hFF) & 'hFC);
        3: bus_addr = 20'hFFFFC;
        default: bus_addr = 20'(offs[$urandom_range(0, 11)]);
      endcase
      bus_wdata = $urandom;
    end
    @(negedge clk);
    bus_valid = 1'b0;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule